// File: doc/BRIEF.md
# Low-Memory Page Control Port

This block is a single 8-bit control port, written by the CPU through I/O address 23, that decides what the processor sees in the bottom 16 kB of its address space. The options are the built-in system ROM, one of 32 pages of an external ROM, or one of 32 pages of an external SRAM. The stored byte also says whether CPU writes into that window may reach the external memory.

Writing a byte with both mapping bits set does not store an illegal combination. It forces the register to external ROM page 0 with writes blocked (value 0x80) and asks for a CPU reset through a pulse of fixed length. The memory chips themselves, and the rest of the address decoding, sit outside this block.

Top module: `lowmem_page_ctl`

## Requirements
- R1: After reset the stored byte is 0x00: page is 0, sysrom_en is 1, rom_sel, sram_sel, lowmem_we and cpu_rst are 0.
- R2: A write strobe whose io_addr is not 23 leaves every output as it was.
- R3: A write to address 23 with bits [7:6] not both 1 stores the byte, and bits [4:0] appear on page from the next cycle.
- R4: A stored byte with bit 6 = 1 and bit 7 = 0 drives sram_sel high and rom_sel and sysrom_en low.
- R5: A stored byte with bit 7 = 1 and bit 6 = 0 drives rom_sel high and sram_sel and sysrom_en low.
- R6: A stored byte with bits [7:6] = 00 drives sysrom_en high and both external selects low.
- R7: A write to address 23 with bits [7:6] = 11 stores 0x80 instead: rom_sel = 1, page = 0, sysrom_en = 0, writes blocked.
- R8: That special write raises cpu_rst in the cycle after the write edge for exactly RST_CYCLES (default 16) clocks; a second special write during the pulse restarts the count.
- R9: lowmem_we is high exactly when mem_wr is high, mem_addr is below 0x4000, an external memory is mapped and stored bit 5 is 1.
- R10: Exactly one of sysrom_en, rom_sel and sram_sel is high in every cycle.
- R11: With io_wr low, io_addr and io_data have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| io_addr | input | 8 | Low byte of the I/O address |
| io_data | input | 8 | I/O write data |
| io_wr | input | 1 | I/O write strobe, one clock per write |
| mem_addr | input | 16 | CPU memory address |
| mem_wr | input | 1 | CPU memory write strobe |
| page | output | 5 | Selected 16 kB external page |
| rom_sel | output | 1 | External ROM mapped into the low window |
| sram_sel | output | 1 | External SRAM mapped into the low window |
| sysrom_en | output | 1 | System ROM mapped into the low window |
| lowmem_we | output | 1 | Write enable for the mapped external memory |
| cpu_rst | output | 1 | CPU reset pulse after the special write |

## Verification
The embedded properties watch, on every clock, that the three map selects stay mutually exclusive, that the register only moves on a decoded write, that the special write always lands on 0x80 and starts the reset pulse, and that the write enable never fires outside the low window or against the system ROM. The exact pulse length, the restart of the pulse by a second special write, and the full byte-to-output mapping for many values come only from the bench, whose behavioural model is compared against every output on every clock through sequences of normal, foreign-address, strobe-less and special writes.

// File: rtl/lowmem_pkg.sv
package lowmem_pkg;
  // Bit layout of the stored control byte: [7] ext ROM, [6] ext SRAM,
  // [5] write allow, [4:0] page.
  typedef struct packed {
    logic       rom_en;
    logic       sram_en;
    logic       wr_en;
    logic [4:0] page;
  } lowmem_ctl_t;

  localparam lowmem_ctl_t CTL_RESET  = '{rom_en: 1'b0, sram_en: 1'b0, wr_en: 1'b0, page: 5'd0};
  localparam lowmem_ctl_t CTL_FORCED = '{rom_en: 1'b1, sram_en: 1'b0, wr_en: 1'b0, page: 5'd0};
endpackage

// File: rtl/lowmem_ctl_reg.sv
module lowmem_ctl_reg
  import lowmem_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int PORT_ADDR = 23
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [7:0]        io_data,
  input  logic              io_wr,
  output lowmem_ctl_t       ctl_q,
  output logic              force_rst
);
  logic        hit;
  logic        both_set;
  lowmem_ctl_t ctl_d;

  always_comb begin
    hit       = io_wr && (io_addr == ADDR_W'(PORT_ADDR));
    both_set  = io_data[7] && io_data[6];
    force_rst = hit && both_set;
    ctl_d     = ctl_q;
    if (hit) begin
      ctl_d = both_set ? CTL_FORCED : lowmem_ctl_t'(io_data);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= CTL_RESET;
    end else if (hit) begin
      ctl_q <= ctl_d;
    end
  end

  // R2 / R11: no decoded write, no change
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |=> $stable(ctl_q));
  // R7: special write lands on the forced value
  p_forced_r7: assert property (@(posedge clk) disable iff (!rst_n)
    force_rst |=> (ctl_q == CTL_FORCED));
  // R10: both mapping bits are never held together
  p_no_both_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(ctl_q.rom_en && ctl_q.sram_en));
endmodule

// File: rtl/lowmem_rst_pulse.sv
module lowmem_rst_pulse #(
  parameter int RST_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic cpu_rst
);
  localparam int CW = $clog2(RST_CYCLES + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    if (start) begin
      cnt_d = CW'(RST_CYCLES);
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end else begin
      cnt_d = cnt_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign cpu_rst = (cnt_q != '0);

  // R8: pulse starts right after the request
  p_rst_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> cpu_rst);
  // R8: pulse cannot appear without a request
  p_rst_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && !cpu_rst) |=> !cpu_rst);
endmodule

// File: rtl/lowmem_map.sv
module lowmem_map
  import lowmem_pkg::*;
#(
  parameter int MEM_AW   = 16,
  parameter int WIN_BITS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  lowmem_ctl_t       ctl,
  input  logic [MEM_AW-1:0] mem_addr,
  input  logic              mem_wr,
  output logic [4:0]        page,
  output logic              rom_sel,
  output logic              sram_sel,
  output logic              sysrom_en,
  output logic              lowmem_we
);
  logic in_window;

  always_comb begin
    in_window = (mem_addr[MEM_AW-1 -: WIN_BITS] == '0);
    page      = ctl.page;
    rom_sel   = ctl.rom_en  && !ctl.sram_en;
    sram_sel  = ctl.sram_en && !ctl.rom_en;
    sysrom_en = !ctl.rom_en && !ctl.sram_en;
    lowmem_we = mem_wr && in_window && (rom_sel || sram_sel) && ctl.wr_en;
  end

  // R10: exactly one source is mapped
  p_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({rom_sel, sram_sel, sysrom_en}) == 1);
  // R9: no write enable outside the window or towards the system ROM
  p_we_window_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lowmem_we |-> (mem_wr && (mem_addr < MEM_AW'(16'h4000)) && !sysrom_en));
endmodule

// File: rtl/lowmem_page_ctl.sv
module lowmem_page_ctl
  import lowmem_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int PORT_ADDR  = 23,
  parameter int MEM_AW     = 16,
  parameter int WIN_BITS   = 2,
  parameter int RST_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [7:0]        io_data,
  input  logic              io_wr,
  input  logic [MEM_AW-1:0] mem_addr,
  input  logic              mem_wr,
  output logic [4:0]        page,
  output logic              rom_sel,
  output logic              sram_sel,
  output logic              sysrom_en,
  output logic              lowmem_we,
  output logic              cpu_rst
);
  logic [1:0]  rst_sync_q;
  logic        rst_int_n;
  lowmem_ctl_t ctl_q;
  logic        force_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  lowmem_ctl_reg #(.ADDR_W(ADDR_W), .PORT_ADDR(PORT_ADDR)) u_reg (
    .clk(clk), .rst_n(rst_int_n), .io_addr(io_addr), .io_data(io_data),
    .io_wr(io_wr), .ctl_q(ctl_q), .force_rst(force_rst)
  );

  lowmem_rst_pulse #(.RST_CYCLES(RST_CYCLES)) u_pulse (
    .clk(clk), .rst_n(rst_int_n), .start(force_rst), .cpu_rst(cpu_rst)
  );

  lowmem_map #(.MEM_AW(MEM_AW), .WIN_BITS(WIN_BITS)) u_map (
    .clk(clk), .rst_n(rst_int_n), .ctl(ctl_q), .mem_addr(mem_addr),
    .mem_wr(mem_wr), .page(page), .rom_sel(rom_sel), .sram_sel(sram_sel),
    .sysrom_en(sysrom_en), .lowmem_we(lowmem_we)
  );
endmodule

// File: tb/sim_lowmem_page_ctl.sv
module sim_lowmem_page_ctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  io_addr = 8'd0;
  logic [7:0]  io_data = 8'd0;
  logic        io_wr = 1'b0;
  logic [15:0] mem_addr = 16'd0;
  logic        mem_wr = 1'b0;
  logic [4:0]  page;
  logic        rom_sel, sram_sel, sysrom_en, lowmem_we, cpu_rst;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  lowmem_page_ctl u0 (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_data(io_data),
    .io_wr(io_wr), .mem_addr(mem_addr), .mem_wr(mem_wr), .page(page),
    .rom_sel(rom_sel), .sram_sel(sram_sel), .sysrom_en(sysrom_en),
    .lowmem_we(lowmem_we), .cpu_rst(cpu_rst)
  );

  // behavioural reference model
  int m_reg = 0;
  int m_cnt = 0;
  bit m_s0 = 0, m_s1 = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s0 = 0; m_s1 = 0; m_reg = 0; m_cnt = 0;
    end else begin
      if (m_s1) begin
        if (m_cnt > 0) m_cnt = m_cnt - 1;
        if (io_wr && io_addr == 8'd23) begin
          if (io_data[7] && io_data[6]) begin
            m_reg = 8'h80;
            m_cnt = 16;
          end else begin
            m_reg = int'(io_data);
          end
        end
      end
      m_s1 = m_s0;
      m_s0 = 1;
    end
  end

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    bit ext_rom  = (m_reg[7:6] == 2'b10);
    bit ext_sram = (m_reg[7:6] == 2'b01);
    bit we = mem_wr && (mem_addr < 16'h4000) && (ext_rom || ext_sram) && m_reg[5];
    check("R3 page", int'(page), m_reg & 31);
    check("R5 rom_sel", int'(rom_sel), int'(ext_rom));
    check("R4 sram_sel", int'(sram_sel), int'(ext_sram));
    check("R6 sysrom_en", int'(sysrom_en), int'(m_reg[7:6] == 2'b00));
    check("R9 lowmem_we", int'(lowmem_we), int'(we));
    check("R8 cpu_rst", int'(cpu_rst), int'(m_cnt != 0));
    check("R10 onehot", int'(rom_sel) + int'(sram_sel) + int'(sysrom_en), 1);
  endtask

  task automatic cyc();
    @(posedge clk);
    #4;
    cycles++;
    compare_all();
  endtask

  task automatic port_wr(logic [7:0] a, logic [7:0] d);
    io_addr = a; io_data = d; io_wr = 1'b1;
    cyc();
    io_wr = 1'b0;
  endtask

  task automatic mem_probe(logic [15:0] a, string req, bit exp);
    mem_addr = a; mem_wr = 1'b1;
    #1;
    check(req, int'(lowmem_we), int'(exp));
    cyc();
    mem_wr = 1'b0;
  endtask

  initial begin
    int n;
    #25 rst_n = 1'b1;
    repeat (4) cyc();
    // R1 reset state
    check("R1 page", int'(page), 0);
    check("R1 sysrom_en", int'(sysrom_en), 1);
    check("R1 selects", int'({rom_sel, sram_sel, lowmem_we, cpu_rst}), 0);
    mem_probe(16'h0100, "R9 sysrom blocks write", 1'b0);

    // R4 SRAM page 10, writes blocked
    port_wr(8'd23, 8'h4A);
    check("R3 page 10", int'(page), 10);
    check("R4 sram mapped", int'({sram_sel, rom_sel, sysrom_en}), 3'b100);
    mem_probe(16'h0000, "R9 write protect", 1'b0);

    // R4/R9 SRAM page 5, writes allowed
    port_wr(8'd23, 8'h65);
    mem_probe(16'h3FFF, "R9 top of window", 1'b1);
    mem_probe(16'h4000, "R9 above window", 1'b0);
    mem_probe(16'hFFFF, "R9 high memory", 1'b0);

    // R5 ROM page 31, writes allowed
    port_wr(8'd23, 8'hBF);
    check("R5 rom mapped", int'({rom_sel, sram_sel, sysrom_en}), 3'b100);
    check("R3 page 31", int'(page), 31);
    mem_probe(16'h2000, "R9 rom writable", 1'b1);

    // R2 foreign addresses ignored
    port_wr(8'd24, 8'h00);
    port_wr(8'd22, 8'h4C);
    port_wr(8'h97, 8'hC0);
    check("R2 ignored", int'({rom_sel, page}), {1'b1, 5'd31});
    check("R2 no reset", int'(cpu_rst), 0);

    // R11 no strobe, no effect
    io_addr = 8'd23; io_data = 8'hC3; io_wr = 1'b0;
    repeat (3) cyc();
    check("R11 no strobe", int'({rom_sel, cpu_rst, page}), {1'b1, 1'b0, 5'd31});

    // R6 back to system ROM with write bit set
    port_wr(8'd23, 8'h3F);
    check("R6 system rom", int'({sysrom_en, rom_sel, sram_sel}), 3'b100);
    mem_probe(16'h0010, "R9 sysrom with bit5", 1'b0);

    // R7 / R8 special write
    port_wr(8'd23, 8'hE7);
    check("R7 forced rom", int'({rom_sel, sram_sel, sysrom_en}), 3'b100);
    check("R7 page 0", int'(page), 0);
    n = 0;
    while (cpu_rst && n < 40) begin n++; cyc(); end
    check("R8 pulse length", n, 16);
    mem_probe(16'h0000, "R7 write protected", 1'b0);

    // R8 restart during pulse
    port_wr(8'd23, 8'hFF);
    repeat (5) cyc();
    port_wr(8'd23, 8'hC0);
    n = 0;
    while (cpu_rst && n < 40) begin n++; cyc(); end
    check("R8 restarted pulse", n, 16);

    // normal write afterwards
    port_wr(8'd23, 8'h52);
    check("R4 sram after reset", int'({sram_sel, page}), {1'b1, 5'd18});

    // R1 asynchronous reset mid-run
    #3 rst_n = 1'b0;
    #1;
    check("R1 async reset", int'({sysrom_en, sram_sel, page}), {1'b1, 1'b0, 5'd0});
    #20 rst_n = 1'b1;
    repeat (4) cyc();
    port_wr(8'd23, 8'h81);
    check("R5 after reset", int'({rom_sel, page}), {1'b1, 5'd1});
    repeat (3) cyc();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule